// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block gathers a set of interrupt request lines and reports one of them to a processor. Every line passes through a two-flop synchronizer and is then judged by its own trigger mode: active-low level, active-high level, falling edge or rising edge. An edge event is held in a per-line latch until software clears it with a command write. Each line has a 3-bit priority level. Level 0 keeps the line out of arbitration. A global threshold register passes only lines whose level is above it.

Every cycle, an arbiter picks the pending, eligible line with the highest level. When two such lines share a level, the lower line number wins. The winner's number and level appear in a read-only status word, together with a flag that is set while nothing is pending. A single active-high interrupt output follows the inverse of that flag, one clock later. Software reaches all registers through a plain single-cycle read/write bus. Writes take effect at the clock edge, and read data is combinational from the address.

The word address map is: 0 control, 1 threshold, 2 status, 3 clear command, 4 and up for the mode registers, 8 to 15 for the level registers.

Top module: `prio_intc`

## Requirements
- R1: After reset, the status word reads 0x0001_0000 (no-pending flag set, level and vector 0), `irq_out` is 0, and every mode register and level register reads 0.
- R2: Level modes: with mode code 00 a line is pending while its input is low, and with mode code 01 while its input is high. A level-mode line stops being pending once its input returns to the inactive value.
- R3: Edge modes: mode code 10 latches a falling edge and code 11 latches a rising edge. Bit 1 of the code selects edge behaviour. The latch stays set after the input returns to idle.
- R4: A write to the clear-command register (address 3) clears the edge latch of the line named in bits 4:0, but only if bit 8 is 1. A write with bit 8 at 0, or one naming another line, leaves the latch set.
- R5: Line s keeps its level in bits [o+2:o] of level register (s mod 16)/2, where o = 16*(s/16) + 8*(s mod 2). The other bits of each 8-bit field read 0. A line whose level is 0 is never reported.
- R6: With threshold T (address 1, bits 2:0), a line is eligible only if T is nonzero and its level is greater than T. T = 0 blocks every line.
- R7: While bit 0 of the control register (address 0) is 0, no line is reported: the flag reads 1 and `irq_out` falls to 0.
- R8: Among eligible pending lines, the highest level wins, and a tie goes to the lowest line number.
- R9: Status word (address 2): bit 16 is 1 when nothing is pending. Bits 10:8 hold the winner's level and bits 4:0 its line number. All other bits read 0.
- R10: `irq_out` equals the inverse of the status flag, delayed by exactly one clock.
- R11: Line s keeps its mode code in bits [2*(s mod 8)+1 : 2*(s mod 8)] of mode register s/8, at address 4 + s/8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Raw request lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt to the processor, active high |

## Verification
A stuck or wrongly cleared edge latch shows up in the status word three clocks after the input moves. It appears as a vector that stays after a clear, or one that vanishes when the input returns to idle. A fault in the arbiter or the threshold compare shows at once as a wrong vector or level in the status read, or as a wrong flag. A fault in the registered output shows one clock later as `irq_out` disagreeing with that flag. Faults in how fields are packed show in read-back, and also as a line that reacts to a different line's mode or level.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int LVL_W   = 3;
    localparam int VEC_W   = 5;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int LVL_REGS = 8;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_THRESH = 4'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE0  = 4'd4;
    localparam logic [ADDR_W-1:0] A_LVL0   = 4'd8;

    localparam int FLAG_BIT = 16;
    localparam int LVL_LSB  = 8;
    localparam int CLR_EN   = 8;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic [DATA_W-1:0]             status_word,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          enable,
    output logic [LVL_W-1:0]              thresh,
    output logic [NUM_SRC-1:0][1:0]       mode,
    output logic [NUM_SRC-1:0][LVL_W-1:0] level,
    output logic                          clr_valid,
    output logic [VEC_W-1:0]              clr_src
);
    localparam int MODE_REGS = (NUM_SRC + 7) / 8;

    typedef struct packed {
        logic                          en;
        logic [LVL_W-1:0]              thr;
        logic [NUM_SRC-1:0][1:0]       mode;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_hit;
    int    widx;

    always_comb begin
        r_d    = r_q;
        wr_hit = bus_sel && bus_wr;
        widx   = int'(bus_addr);
        if (wr_hit) begin
            if (bus_addr == A_CTRL)   r_d.en  = bus_wdata[0];
            if (bus_addr == A_THRESH) r_d.thr = bus_wdata[LVL_W-1:0];
            for (int s = 0; s < NUM_SRC; s++) begin
                if (widx == int'(A_MODE0) + s / 8)
                    r_d.mode[s] = bus_wdata[2*(s%8) +: 2];
                if (widx == int'(A_LVL0) + (s % 16) / 2)
                    r_d.lvl[s] = bus_wdata[16*(s/16) + 8*(s%2) +: LVL_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)   bus_rdata[0] = r_q.en;
        if (bus_addr == A_THRESH) bus_rdata[LVL_W-1:0] = r_q.thr;
        if (bus_addr == A_STATUS) bus_rdata = status_word;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (widx == int'(A_MODE0) + s / 8)
                bus_rdata[2*(s%8) +: 2] = r_q.mode[s];
            if (widx == int'(A_LVL0) + (s % 16) / 2)
                bus_rdata[16*(s/16) + 8*(s%2) +: LVL_W] = r_q.lvl[s];
        end
    end

    assign enable    = r_q.en;
    assign thresh    = r_q.thr;
    assign mode      = r_q.mode;
    assign level     = r_q.lvl;
    assign clr_valid = wr_hit && (bus_addr == A_CLEAR) && bus_wdata[CLR_EN];
    assign clr_src   = bus_wdata[VEC_W-1:0];

    // R7: a control write lands in the enable bit on the next edge
    assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_CTRL) |=> (enable == $past(bus_wdata[0])));
endmodule

// File: rtl/prio_intc_detect.sv
module prio_intc_detect
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      req_raw,
    input  logic [NUM_SRC-1:0][1:0] mode,
    input  logic                    clr_valid,
    input  logic [VEC_W-1:0]        clr_src,
    output logic [NUM_SRC-1:0]      pending
);
    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] latch;
    } det_t;

    det_t d_d, d_q;
    logic [NUM_SRC-1:0] hit, clr_hit;

    always_comb begin
        d_d      = d_q;
        d_d.s1   = req_raw;
        d_d.s2   = d_q.s1;
        d_d.prev = d_q.s2;
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_hit[i] = clr_valid && (int'(clr_src) == i);
            hit[i]     = mode[i][1] &&
                         (mode[i][0] ? (d_q.s2[i] && !d_q.prev[i])
                                     : (!d_q.s2[i] && d_q.prev[i]));
            d_d.latch[i] = hit[i] || (d_q.latch[i] && !clr_hit[i]);
            pending[i]   = mode[i][1] ? d_q.latch[i]
                                      : (mode[i][0] ? d_q.s2[i] : !d_q.s2[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.s1    <= '1;
            d_q.s2    <= '1;
            d_q.prev  <= '1;
            d_q.latch <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R3: a latched edge survives until a matching clear
        assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (d_q.latch[g] && !clr_hit[g]) |=> d_q.latch[g]);
        // R4: a matching clear with no new edge empties the latch
        assert_latch_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && !hit[g]) |=> !d_q.latch[g]);
    end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic [LVL_W-1:0]              thresh,
    input  logic [NUM_SRC-1:0]            pending,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] level,
    output logic                          none,
    output logic [LVL_W-1:0]              win_lvl,
    output logic [VEC_W-1:0]              win_vec
);
    logic [NUM_SRC-1:0] elig;

    always_comb begin
        none    = 1'b1;
        win_lvl = '0;
        win_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = enable && pending[i] && (thresh != '0) &&
                      (level[i] != '0) && (level[i] > thresh);
            if (elig[i] && (none || level[i] > win_lvl)) begin
                none    = 1'b0;
                win_lvl = level[i];
                win_vec = VEC_W'(i);
            end
        end
    end

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> none);
    assert_above_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !none |-> (thresh != '0 && win_lvl > thresh));
    assert_level_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !none |-> win_lvl != '0);
    assert_idle_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        none |-> (win_lvl == '0 && win_vec == '0));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);
    typedef struct packed {
        logic irq;
    } top_t;

    logic                          enable, clr_valid, none;
    logic [LVL_W-1:0]              thresh, win_lvl;
    logic [VEC_W-1:0]              clr_src, win_vec;
    logic [NUM_SRC-1:0][1:0]       mode;
    logic [NUM_SRC-1:0][LVL_W-1:0] level;
    logic [NUM_SRC-1:0]            pending;
    logic [DATA_W-1:0]             status_word;
    top_t t_d, t_q;

    prio_intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_word(status_word),
        .bus_rdata(bus_rdata), .enable(enable), .thresh(thresh), .mode(mode),
        .level(level), .clr_valid(clr_valid), .clr_src(clr_src)
    );

    prio_intc_detect #(.NUM_SRC(NUM_SRC)) u_det (
        .clk(clk), .rst_n(rst_n), .req_raw(irq_req), .mode(mode),
        .clr_valid(clr_valid), .clr_src(clr_src), .pending(pending)
    );

    prio_intc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .enable(enable), .thresh(thresh),
        .pending(pending), .level(level), .none(none),
        .win_lvl(win_lvl), .win_vec(win_vec)
    );

    always_comb begin
        status_word = '0;
        status_word[FLAG_BIT] = none;
        status_word[LVL_LSB +: LVL_W] = win_lvl;
        status_word[VEC_W-1:0] = win_vec;
        t_d.irq = !none;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq_out = t_q.irq;

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(!none));
    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(none));
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_req = '1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0, bad = 0;
    logic [31:0] mode_sh [2];
    logic [31:0] lvl_sh  [8];

    prio_intc #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_mode(input int s, input logic [1:0] m);
        mode_sh[s/8][2*(s%8) +: 2] = m;
        bwrite(4'(4 + s/8), mode_sh[s/8]);
    endtask

    task automatic set_lvl(input int s, input logic [2:0] l);
        lvl_sh[(s%16)/2][16*(s/16) + 8*(s%2) +: 8] = {5'b0, l};
        bwrite(4'(8 + (s%16)/2), lvl_sh[(s%16)/2]);
    endtask

    function automatic logic [31:0] stat(input bit none, input int l, input int v);
        return none ? 32'h0001_0000 : ((32'(l) << 8) | 32'(v));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 2; i++) mode_sh[i] = '0;
        for (int i = 0; i < 8; i++) lvl_sh[i] = '0;
        wcyc(3);
        rst_n = 1'b1;
        wcyc(2);

        // R1 reset state
        bread(4'd2, rd); check(rd == 32'h0001_0000, "R1 status", rd, 32'h0001_0000);
        check(irq_out == 1'b0, "R1 irq", 32'(irq_out), 0);
        for (int i = 0; i < 2; i++) begin
            bread(4'(4+i), rd); check(rd == 0, "R1 mode reg", rd, 0);
        end
        for (int i = 0; i < 8; i++) begin
            bread(4'(8+i), rd); check(rd == 0, "R1 level reg", rd, 0);
        end

        bwrite(4'd0, 32'h1);
        bwrite(4'd1, 32'h1);

        // per-source, per-mode sweep: R2 R3 R4 R5 R9 R10 R11
        for (int s = 0; s < N; s++) begin
            for (int m = 0; m < 4; m++) begin
                int lv;
                logic idle;
                lv = 2 + (s + m) % 6;
                idle = (m == 1 || m == 3) ? 1'b0 : 1'b1;
                irq_req[s] = idle;
                wcyc(4);
                set_lvl(s, 3'(lv));
                set_mode(s, 2'(m));
                wcyc(4);
                bread(4'd2, rd); check(rd == stat(1, 0, 0), "R2 idle not pending", rd, stat(1, 0, 0));
                bread(4'(4 + s/8), rd); check(rd == mode_sh[s/8], "R11 mode packing", rd, mode_sh[s/8]);
                bread(4'(8 + (s%16)/2), rd); check(rd == lvl_sh[(s%16)/2], "R5 level packing", rd, lvl_sh[(s%16)/2]);
                irq_req[s] = ~idle;
                wcyc(4);
                bread(4'd2, rd); check(rd == stat(0, lv, s), "R9 active status", rd, stat(0, lv, s));
                check(irq_out == 1'b1, "R10 irq high", 32'(irq_out), 1);
                irq_req[s] = idle;
                wcyc(4);
                bread(4'd2, rd);
                if (m < 2) begin
                    check(rd == stat(1, 0, 0), "R2 level released", rd, stat(1, 0, 0));
                    check(irq_out == 1'b0, "R10 irq low", 32'(irq_out), 0);
                end else begin
                    check(rd == stat(0, lv, s), "R3 edge held", rd, stat(0, lv, s));
                    bwrite(4'd3, 32'(s));
                    wcyc(1);
                    bread(4'd2, rd); check(rd == stat(0, lv, s), "R4 clear without enable bit", rd, stat(0, lv, s));
                    bwrite(4'd3, 32'h100 | 32'((s + 1) % N));
                    wcyc(1);
                    bread(4'd2, rd); check(rd == stat(0, lv, s), "R4 clear other line", rd, stat(0, lv, s));
                    bwrite(4'd3, 32'h100 | 32'(s));
                    wcyc(1);
                    bread(4'd2, rd); check(rd == stat(1, 0, 0), "R4 clear matching", rd, stat(1, 0, 0));
                end
                irq_req[s] = 1'b1;
                wcyc(3);
                set_lvl(s, 3'd0);
                set_mode(s, 2'd0);
            end
        end

        // R5 level 0 never reported, even with input active
        set_mode(2, 2'd1);
        irq_req[2] = 1'b1;
        wcyc(4);
        bread(4'd2, rd); check(rd == stat(1, 0, 0), "R5 level zero ignored", rd, stat(1, 0, 0));
        irq_req[2] = 1'b0;
        set_mode(2, 2'd0);
        irq_req[2] = 1'b1;

        // R6 threshold sweep: line 3 at level 5
        set_lvl(3, 3'd5);
        set_mode(3, 2'd1);
        irq_req[3] = 1'b1;
        wcyc(4);
        for (int t = 0; t < 8; t++) begin
            bit pass;
            bwrite(4'd1, 32'(t));
            pass = (t != 0) && (5 > t);
            bread(4'd2, rd); check(rd == stat(!pass, 5, 3), "R6 threshold", rd, stat(!pass, 5, 3));
        end
        bwrite(4'd1, 32'h1);
        wcyc(2);

        // R7 and R10 timing: disable with a line pending
        check(irq_out == 1'b1, "R10 irq before disable", 32'(irq_out), 1);
        bwrite(4'd0, 32'h0);
        bread(4'd2, rd); check(rd == stat(1, 0, 0), "R7 disabled status", rd, stat(1, 0, 0));
        check(irq_out == 1'b1, "R10 irq one cycle late", 32'(irq_out), 1);
        wcyc(1);
        check(irq_out == 1'b0, "R7 irq off", 32'(irq_out), 0);
        bwrite(4'd0, 32'h1);
        irq_req[3] = 1'b0;
        set_lvl(3, 3'd0);
        set_mode(3, 2'd0);
        irq_req[3] = 1'b1;

        // R8 priority among pairs
        for (int a = 0; a < N; a++) begin
            int b, la, lb, w, wl;
            b  = (a * 5 + 3) % N;
            if (b == a) b = (a + 1) % N;
            la = 2 + a % 6;
            lb = 2 + (b * 3) % 6;
            set_lvl(a, 3'(la)); set_lvl(b, 3'(lb));
            set_mode(a, 2'd1);  set_mode(b, 2'd1);
            irq_req[a] = 1'b1;  irq_req[b] = 1'b1;
            wcyc(4);
            if (la > lb)      begin w = a; wl = la; end
            else if (lb > la) begin w = b; wl = lb; end
            else              begin w = (a < b) ? a : b; wl = la; end
            bread(4'd2, rd); check(rd == stat(0, wl, w), "R8 priority", rd, stat(0, wl, w));
            irq_req[a] = 1'b0;  irq_req[b] = 1'b0;
            set_lvl(a, 3'd0); set_lvl(b, 3'd0);
            set_mode(a, 2'd0); set_mode(b, 2'd0);
            irq_req[a] = 1'b1;  irq_req[b] = 1'b1;
            wcyc(3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule